// File: doc/BRIEF.md
# Timer Channel with Selectable Counter Clear

This block is one channel of a multi-channel timer. A 16-bit up-counter advances on count events taken from a prescaled count-enable input. The edge select picks whether a rising level change, a falling level change, or either one counts. Four general registers, named A to D, sit beside the counter. Each one either compares against the counter or captures the counter value when an edge arrives on its own pin.

A 3-bit clear-select field picks which event returns the counter to zero. The choices are a match or capture on one of the four registers, no clear at all, or a synchronized clear that follows the other channels of a sync group. When this channel clears itself while sync is enabled, it signals the other channels through a one-cycle pulse. Registers C and D can be placed in buffer mode. In buffer mode they raise no events of their own, so selecting them as the clear source has no effect.

A parameter builds a reduced variant with a 2-bit clear-select field. In that variant a register B capture also clears the counter.

Top module: `tmr_chan`

## Requirements
- R1: After reset every register reads 0 and `sync_out` is low. The address map is 0 control, 1 mode, 2 counter, 3 status, and 4 to 7 registers A to D. Control holds clear-select in [2:0], edge-select in [4:3] and sync-enable in [5]. Mode holds capture-mode bits for A to D in [3:0] (1 = capture), capture-on-falling-edge in [4], C-buffer in [5] and D-buffer in [6]. Status holds overflow in [0] and the match flags for A to D in [4:1].
- R2: Edge-select 00 counts rising changes of `cnt_in`, 01 counts falling changes, and 1x counts both. With both edges selected, an input that toggles every two clocks advances the counter once per two clocks.
- R3: A register in compare mode whose value equals the counter at a count event sets its status flag and its `match_flag` bit. A flag stays set until software writes 0 to its status bit. Writing 1 leaves it unchanged.
- R4: Clear-select 000 and 100 never clear the counter.
- R5: With clear-select 001, a register A match loads 0 at that count event instead of incrementing. A register A capture makes the next count event load 0.
- R6: Clear-select 010 clears on a register B match. Clear-select 101 clears on a register C match or capture. Clear-select 110 clears on a register D match. The timing is the same as in R5.
- R7: With clear-select 011 or 111 and sync-enable set, a pulse on `sync_in` makes the next count event load 0. With sync-enable clear, `sync_in` is ignored.
- R8: When this channel clears from its own source while sync-enable is set, `sync_out` is high for the one cycle that follows the clear event. Without sync-enable it stays low.
- R9: A register C or D in buffer mode raises no match and no capture, so clear-select 101 or 110 then leaves the counter counting.
- R10: A capture-mode register copies the counter on the selected edge of its pin (rising, or falling when mode[4] is set). The other edge does nothing.
- R11: A count event at 0xFFFF without a clear wraps the counter to 0 and sets the sticky overflow flag. The flag is cleared only by writing 0 to status bit 0.
- R12: In the reduced variant, control bit 2 always reads 0 and ignores writes, and clear-select 010 also clears on a register B capture. In the full variant, a B capture under 010 does not clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, combinational from `rd_addr` |
| cnt_in | input | 1 | Prescaled count-enable level |
| cap_in | input | 4 | Capture pins for registers A to D |
| sync_in | input | 1 | Clear request from the sync group |
| sync_out | output | 1 | One-cycle pulse when this channel clears itself under sync |
| match_flag | output | 4 | Sticky compare-match flags for A to D |

## Verification
The hardest situation to reach is a capture-driven or sync-driven clear. In both cases the request is raised in one cycle and takes effect only at a later count event. The stimulus therefore pulses the capture pin or `sync_in` while `cnt_in` is held still, reads the counter to confirm that nothing has moved yet, and only then supplies a count edge. The `sync_out` pulse is caught by raising a single count edge exactly on the matching value and sampling in the same cycle. A second instance, built as the reduced variant, receives the same writes, which brings out the difference in the B-capture clear.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_MODE = 3'd1,
    A_CNT  = 3'd2,
    A_STAT = 3'd3,
    A_GRA  = 3'd4,
    A_GRB  = 3'd5,
    A_GRC  = 3'd6,
    A_GRD  = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic       sync_en;
    logic [1:0] edge_sel;
    logic [2:0] clr_sel;
  } ctl_t;

  typedef struct packed {
    logic       buf_d;
    logic       buf_c;
    logic       cap_fall;
    logic [3:0] cap_mode;
  } mode_t;

endpackage

// File: rtl/tmr_edge.sv
`timescale 1ns/1ps
module tmr_edge (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sig,
  input  logic [1:0] sel,
  output logic       evt
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig;
  end

  always_comb begin
    rise = sig & ~prev_q;
    fall = ~sig & prev_q;
    if (sel[1])      evt = rise | fall;
    else if (sel[0]) evt = fall;
    else             evt = rise;
  end

  // R2
  evt_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (sig != prev_q));

endmodule

// File: rtl/tmr_greg.sv
`timescale 1ns/1ps
module tmr_greg #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic [CW-1:0] cnt,
  input  logic          tick,
  input  logic          cap_evt,
  input  logic          cap_mode,
  input  logic          blocked,
  output logic [CW-1:0] val,
  output logic          match,
  output logic          cap
);
  logic [CW-1:0] val_q, val_d;

  assign cap   = cap_mode & cap_evt & ~blocked;
  assign match = ~cap_mode & ~blocked & tick & (cnt == val_q);

  always_comb begin
    val_d = val_q;
    if (cap)        val_d = cnt;
    else if (wr_en) val_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign val = val_q;

  // R10
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (val_q == $past(cnt)));

endmodule

// File: rtl/tmr_clr_sel.sv
`timescale 1ns/1ps
module tmr_clr_sel #(
  parameter bit REDUCED = 1'b0
) (
  input  logic [2:0] sel,
  input  logic [3:0] gr_match,
  input  logic [3:0] gr_cap,
  input  logic       sync_req,
  output logic       clr_match,
  output logic       clr_cap,
  output logic       clr_sync
);
  logic [2:0] sel_eff;

  always_comb begin
    sel_eff   = REDUCED ? {1'b0, sel[1:0]} : sel;
    clr_match = 1'b0;
    clr_cap   = 1'b0;
    clr_sync  = 1'b0;
    case (sel_eff)
      3'b001: begin clr_match = gr_match[0]; clr_cap = gr_cap[0]; end
      3'b010: begin clr_match = gr_match[1]; clr_cap = REDUCED & gr_cap[1]; end
      3'b101: begin clr_match = gr_match[2]; clr_cap = gr_cap[2]; end
      3'b110: clr_match = gr_match[3];
      3'b011, 3'b111: clr_sync = sync_req;
      default: ;
    endcase
  end

endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CW      = 16,
  parameter bit REDUCED = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  input  logic          cnt_in,
  input  logic [3:0]    cap_in,
  input  logic          sync_in,
  output logic          sync_out,
  output logic [3:0]    match_flag
);
  localparam int NGR    = 4;
  localparam int CTL_W  = $bits(ctl_t);
  localparam int MODE_W = $bits(mode_t);
  localparam logic [CW-1:0] ONE     = CW'(1);
  localparam logic [CW-1:0] CNT_MAX = '1;

  // reset synchronizer: asynchronous assert, synchronous release
  logic rst_m_q, rst_s_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s_q, rst_m_q} <= 2'b00;
    else        {rst_s_q, rst_m_q} <= {rst_m_q, 1'b1};
  end
  assign srst_n = rst_s_q;

  ctl_t          ctl_q, ctl_d;
  mode_t         mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d, pend_q, pend_d, sync_q, sync_d;
  logic [NGR-1:0] flg_q, flg_d;

  logic wr_ctl, wr_mode, wr_cnt, wr_stat, tick, wrap;
  logic clr_match, clr_cap, clr_sync;
  logic [NGR-1:0] gr_match, gr_cap, cap_evt, wr_gr, blocked;
  logic [CW-1:0]  gr_val [NGR];

  assign wr_ctl  = wr_en && (wr_addr == A_CTRL);
  assign wr_mode = wr_en && (wr_addr == A_MODE);
  assign wr_cnt  = wr_en && (wr_addr == A_CNT);
  assign wr_stat = wr_en && (wr_addr == A_STAT);
  assign blocked = {mode_q.buf_d, mode_q.buf_c, 2'b00};

  tmr_edge u_cnt_edge (
    .clk(clk), .rst_n(srst_n), .sig(cnt_in), .sel(ctl_q.edge_sel), .evt(tick)
  );

  for (genvar i = 0; i < NGR; i++) begin : g_gr
    assign wr_gr[i] = wr_en && (wr_addr == 3'(32'(A_GRA) + i));

    tmr_edge u_cap_edge (
      .clk(clk), .rst_n(srst_n), .sig(cap_in[i]),
      .sel({1'b0, mode_q.cap_fall}), .evt(cap_evt[i])
    );

    tmr_greg #(.CW(CW)) u_gr (
      .clk(clk), .rst_n(srst_n), .wr_en(wr_gr[i]), .wr_data(wr_data),
      .cnt(cnt_q), .tick(tick), .cap_evt(cap_evt[i]),
      .cap_mode(mode_q.cap_mode[i]), .blocked(blocked[i]),
      .val(gr_val[i]), .match(gr_match[i]), .cap(gr_cap[i])
    );
  end

  tmr_clr_sel #(.REDUCED(REDUCED)) u_clr (
    .sel(ctl_q.clr_sel), .gr_match(gr_match), .gr_cap(gr_cap),
    .sync_req(sync_in & ctl_q.sync_en),
    .clr_match(clr_match), .clr_cap(clr_cap), .clr_sync(clr_sync)
  );

  // next-state logic
  always_comb begin
    ctl_d  = ctl_q;
    mode_d = mode_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    ovf_d  = ovf_q;
    flg_d  = flg_q;
    wrap   = 1'b0;

    if (wr_ctl) begin
      ctl_d = ctl_t'(wr_data[CTL_W-1:0]);
      if (REDUCED) ctl_d.clr_sel[2] = 1'b0;
    end
    if (wr_mode) mode_d = mode_t'(wr_data[MODE_W-1:0]);

    if (tick && !wr_cnt)     pend_d = 1'b0;
    if (clr_cap || clr_sync) pend_d = 1'b1;

    if (wr_cnt) begin
      cnt_d = wr_data;
    end else if (tick) begin
      if (clr_match || pend_q) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + ONE;
        wrap  = (cnt_q == CNT_MAX);
      end
    end

    if (wr_stat) begin
      ovf_d = ovf_q & wr_data[0];
      flg_d = flg_q & wr_data[NGR:1];
    end
    if (wrap) ovf_d = 1'b1;
    flg_d = flg_d | gr_match;

    sync_d = ctl_q.sync_en & (clr_match | clr_cap);
  end

  // state registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctl_q  <= '0;
      mode_q <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
      flg_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      ovf_q  <= ovf_d;
      flg_q  <= flg_d;
      sync_q <= sync_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_addr_e'(rd_addr))
      A_CTRL:  rd_data[CTL_W-1:0]  = ctl_q;
      A_MODE:  rd_data[MODE_W-1:0] = mode_q;
      A_CNT:   rd_data             = cnt_q;
      A_STAT:  rd_data[NGR:0]      = {flg_q, ovf_q};
      default: rd_data             = gr_val[rd_addr[1:0]];
    endcase
  end

  assign sync_out   = sync_q;
  assign match_flag = flg_q;

  // R4
  no_clear_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (ctl_q.clr_sel[1:0] == 2'b00 && tick && !wr_cnt && !pend_q)
      |=> (cnt_q == $past(cnt_q) + ONE));

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (ovf_q && !(wr_stat && !wr_data[0])) |=> ovf_q);

  // R8
  sync_out_chk: assert property (@(posedge clk) disable iff (!srst_n)
    sync_out |-> $past(ctl_q.sync_en));

  // R9
  buf_silent_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (mode_q.buf_c || mode_q.buf_d)
      |-> !((mode_q.buf_c && (gr_match[2] || gr_cap[2])) ||
            (mode_q.buf_d && (gr_match[3] || gr_cap[3]))));

  if (REDUCED) begin : g_red_chk
    // R12
    resv_bit_chk: assert property (@(posedge clk) disable iff (!srst_n)
      (rd_addr == A_CTRL) |-> !rd_data[2]);
  end

endmodule

// File: tb/tmr_chan_tb.sv
`timescale 1ns/1ps
module tmr_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, cnt_in, sync_in;
  logic [2:0]  wr_addr, rd_addr;
  logic [15:0] wr_data;
  logic [3:0]  cap_in;
  wire  [15:0] rd_full, rd_red;
  wire         so_full, so_red;
  wire  [3:0]  mf_full, mf_red;

  always #5 clk = ~clk;

  tmr_chan #(.CW(16), .REDUCED(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_full), .cnt_in(cnt_in), .cap_in(cap_in),
    .sync_in(sync_in), .sync_out(so_full), .match_flag(mf_full));

  tmr_chan #(.CW(16), .REDUCED(1'b1)) u_red (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_red), .cnt_in(cnt_in), .cap_in(cap_in),
    .sync_in(sync_in), .sync_out(so_red), .match_flag(mf_red));

  // sources: 0 full read, 1 reduced read, 2 sync_out, 3 match_flag
  typedef struct {
    int          src;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  localparam logic [2:0] CTRL = 3'd0, MODE = 3'd1, CNT = 3'd2, STAT = 3'd3,
                         GRA = 3'd4, GRB = 3'd5, GRC = 3'd6, GRD = 3'd7;

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    item_t       it;
    logic [15:0] act;
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      case (it.src)
        0:       act = rd_full;
        1:       act = rd_red;
        2:       act = {15'd0, so_full};
        default: act = {12'd0, mf_full};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_val(int src, logic [2:0] addr, logic [15:0] exp, string tag);
    item_t it;
    rd_addr = addr;
    it.src = src; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    wait (sbq.size() == 0);
  endtask

  task automatic wr(logic [2:0] addr, logic [15:0] data);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic tick(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1 cnt_in = 1'b1;
      @(posedge clk); #1 cnt_in = 1'b0;
      @(posedge clk); #1;
    end
  endtask

  task automatic pulse_cap(int idx);
    @(posedge clk); #1 cap_in[idx] = 1'b1;
    @(posedge clk); #1 cap_in[idx] = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic pulse_sync();
    @(posedge clk); #1 sync_in = 1'b1;
    @(posedge clk); #1 sync_in = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    cnt_in = 1'b0; cap_in = '0; sync_in = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset state
    expect_val(0, CTRL, 16'h0000, "R1 ctrl");
    expect_val(0, MODE, 16'h0000, "R1 mode");
    expect_val(0, CNT,  16'h0000, "R1 count");
    expect_val(0, STAT, 16'h0000, "R1 status");
    expect_val(0, GRA,  16'h0000, "R1 reg A");
    expect_val(0, GRD,  16'h0000, "R1 reg D");
    expect_val(2, CTRL, 16'h0000, "R1 sync_out");

    wr(GRB, 16'h8000); wr(GRC, 16'h8000); wr(GRD, 16'h8000);

    // R2 edge selection
    wr(CNT, 16'h0); tick(5);
    expect_val(0, CNT, 16'd5, "R2 rising");
    wr(CTRL, 16'h0008); wr(CNT, 16'h0); tick(3);
    expect_val(0, CNT, 16'd3, "R2 falling");
    wr(CTRL, 16'h0010); wr(CNT, 16'h0); tick(2);
    expect_val(0, CNT, 16'd4, "R2 both edges");
    wr(CNT, 16'h0);
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #1 cnt_in = ~cnt_in;
      @(posedge clk);
    end
    @(posedge clk); #1;
    expect_val(0, CNT, 16'd8, "R2 both edges of divided input");

    // R3 / R5 compare match clear on A
    wr(GRA, 16'd3); wr(CTRL, 16'h0001); wr(STAT, 16'h0); wr(CNT, 16'h0);
    tick(4);
    expect_val(0, CNT,  16'd0,    "R5 A match clears");
    expect_val(0, STAT, 16'h0002, "R3 A flag in status");
    expect_val(3, CTRL, 16'h0001, "R3 match_flag port");
    wr(STAT, 16'h0002);
    expect_val(0, STAT, 16'h0002, "R3 write 1 keeps flag");
    wr(STAT, 16'h0000);
    expect_val(0, STAT, 16'h0000, "R3 write 0 clears flag");

    // R4 disabled clear
    wr(CTRL, 16'h0000); wr(CNT, 16'h0); tick(5);
    expect_val(0, CNT, 16'd5, "R4 code 000");
    wr(CTRL, 16'h0004); wr(CNT, 16'h0); tick(5);
    expect_val(0, CNT, 16'd5, "R4 code 100");

    // R6 B and D compare clear
    wr(GRB, 16'd2); wr(CTRL, 16'h0002); wr(CNT, 16'h0); tick(3);
    expect_val(0, CNT, 16'd0, "R6 B match clears");
    wr(GRD, 16'd1); wr(CTRL, 16'h0006); wr(CNT, 16'h0); tick(2);
    expect_val(0, CNT, 16'd0, "R6 D match clears");

    // R9 buffer suppression
    wr(GRC, 16'd2); wr(MODE, 16'h0020); wr(CTRL, 16'h0005); wr(CNT, 16'h0); tick(4);
    expect_val(0, CNT, 16'd4, "R9 C buffered no clear");
    wr(MODE, 16'h0000); wr(CNT, 16'h0); tick(3);
    expect_val(0, CNT, 16'd0, "R6 C match clears");
    wr(MODE, 16'h0040); wr(CTRL, 16'h0006); wr(CNT, 16'h0); tick(2);
    expect_val(0, CNT, 16'd2, "R9 D buffered no clear");

    // R6 C capture clear
    wr(MODE, 16'h0004); wr(CTRL, 16'h0005); wr(CNT, 16'd9);
    pulse_cap(2);
    expect_val(0, GRC, 16'd9, "R10 C capture value");
    tick(1);
    expect_val(0, CNT, 16'd0, "R6 C capture clears");

    // R10 / R5 capture on A
    wr(MODE, 16'h0001); wr(CTRL, 16'h0001); wr(CNT, 16'd10);
    pulse_cap(0);
    expect_val(0, GRA, 16'd10, "R10 A rising capture");
    expect_val(0, CNT, 16'd10, "R5 capture clear waits for count");
    tick(1);
    expect_val(0, CNT, 16'd0, "R5 A capture clears at count");
    wr(MODE, 16'h0011); wr(CTRL, 16'h0000); wr(CNT, 16'd20);
    @(posedge clk); #1 cap_in[0] = 1'b1;
    @(posedge clk); #1;
    expect_val(0, GRA, 16'd10, "R10 rising ignored in falling mode");
    cap_in[0] = 1'b0;
    @(posedge clk); #1;
    expect_val(0, GRA, 16'd20, "R10 falling capture");

    // R7 synchronized clear
    wr(MODE, 16'h0000); wr(CTRL, 16'h0023); wr(CNT, 16'd7);
    pulse_sync();
    expect_val(0, CNT, 16'd7, "R7 sync waits for count");
    tick(1);
    expect_val(0, CNT, 16'd0, "R7 sync clear");
    wr(CTRL, 16'h0003); wr(CNT, 16'd7);
    pulse_sync(); tick(1);
    expect_val(0, CNT, 16'd8, "R7 sync ignored without enable");

    // R8 sync_out pulse
    wr(GRA, 16'd1); wr(CTRL, 16'h0021); wr(CNT, 16'h0); tick(1);
    @(posedge clk); #1 cnt_in = 1'b1;
    @(posedge clk); #1;
    expect_val(2, CTRL, 16'h0001, "R8 sync_out high after own clear");
    expect_val(0, CNT,  16'h0000, "R8 counter cleared");
    cnt_in = 1'b0;
    @(posedge clk); #1;
    expect_val(2, CTRL, 16'h0000, "R8 sync_out one cycle");
    wr(CTRL, 16'h0001); wr(CNT, 16'h0); tick(1);
    @(posedge clk); #1 cnt_in = 1'b1;
    @(posedge clk); #1;
    expect_val(2, CTRL, 16'h0000, "R8 no pulse without sync enable");
    cnt_in = 1'b0;
    @(posedge clk); #1;

    // R11 overflow
    wr(CTRL, 16'h0000); wr(STAT, 16'h0000); wr(CNT, 16'hFFFF); tick(1);
    expect_val(0, CNT,  16'h0000, "R11 wrap");
    expect_val(0, STAT, 16'h0001, "R11 overflow set");
    wr(STAT, 16'h0001);
    expect_val(0, STAT, 16'h0001, "R11 write 1 keeps overflow");
    wr(STAT, 16'h0000);
    expect_val(0, STAT, 16'h0000, "R11 write 0 clears overflow");

    // R12 reduced variant
    wr(CTRL, 16'h0007);
    expect_val(0, CTRL, 16'h0007, "R12 full keeps bit 2");
    expect_val(1, CTRL, 16'h0003, "R12 reduced bit 2 reads 0");
    wr(MODE, 16'h0002); wr(CTRL, 16'h0002); tick(1); wr(CNT, 16'd5);
    pulse_cap(1);
    expect_val(1, GRB, 16'd5, "R12 reduced B capture value");
    tick(1);
    expect_val(1, CNT, 16'd0, "R12 reduced B capture clears");
    expect_val(0, CNT, 16'd6, "R12 full B capture no clear");

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule